// File: doc/BRIEF.md
# Branch Target and Direction Predictor

This block sits beside the fetch stage. Each cycle, fetch presents a PC together with one bit that says whether that instruction's branch displacement is negative. In the same cycle, the block returns three things: a hit flag, a taken/not-taken direction and the predicted next fetch address.

A direct-mapped table is indexed by the word bits of the PC just above the byte offset. Each entry holds a tag, a branch target and a short outcome history for that one branch. On a tagged hit, the direction comes from a separate table of 2-bit saturating counters. That table is indexed by the PC index XORed with the entry's history. On a miss, a static rule decides the direction: backward branches are predicted taken and forward branches not taken.

When a branch resolves later in the pipeline, its outcome is reported on the resolve port. A tag hit trains the entry and its counter. A taken branch that misses allocates a new entry. A not-taken branch that misses changes nothing.

Top module: `btb_dir_pred`

## Requirements
- R1: `lk_hit`, `lk_taken` and `lk_next_pc` depend only on the current lookup inputs and the stored state, with no clock cycle of latency.
- R2: `lk_hit` is 1 only when the entry at index `lk_pc[10:2]` is valid and its stored tag equals `lk_pc[31:11]`. A PC that differs only above bit 10 from an allocated branch misses.
- R3: On a hit, `lk_taken` is bit 1 of the 2-bit counter at index `lk_pc[10:2]` XOR the entry's 4-bit history, zero-extended to 9 bits. `lk_next_pc` is the stored target when `lk_taken` is 1 and `lk_pc + 4` otherwise.
- R4: On a miss, `lk_next_pc` is `lk_pc + 4`.
- R5: On a miss, `lk_taken` equals `lk_back`: 1 for a negative displacement and 0 for a positive one.
- R6: When a resolved branch hits its entry, the counter at its PC index XOR its pre-update history moves up by one if the branch was taken and down by one if not. The counter saturates at 3 and at 0, so two wrong outcomes in a row are needed to flip a strongly biased prediction.
- R7: A taken resolve that misses writes the entry at its index: valid, the new tag, the target and a history of 0. This replaces any earlier branch held there. It also sets the counter at the plain PC index to 2 (weakly taken).
- R8: A not-taken resolve that misses leaves every entry and every counter unchanged.
- R9: A resolve that hits shifts the outcome (1 for taken) into bit 0 of the entry's history, dropping bit 3. A taken outcome also replaces the stored target.
- R10: Updates take effect at the next rising clock edge. A lookup in the same cycle as an update to the same entry returns the old contents.
- R11: A synchronous reset clears every valid bit and sets every counter to 1 (weakly not taken).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_back | input | 1 | 1 when the looked-up branch has a negative displacement |
| lk_hit | output | 1 | Tag match in the target table |
| lk_taken | output | 1 | Predicted direction |
| lk_next_pc | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_pc | input | 30 | Word address (PC bits 31:2) of the resolved branch |
| rs_taken | input | 1 | Actual outcome of the resolved branch |
| rs_target | input | 32 | Actual target of the resolved branch |

## Verification
A corrupted tag or valid bit shows up on the first lookup of that branch: `lk_hit` is wrong and `lk_next_pc` falls back to the sequential address. A wrong history or counter does not show up at once. It appears only after that counter's history pattern recurs, so the bench replays repeating loop patterns and a long pseudo-random mix against a reference model, comparing every lookup in the same cycle. The same-cycle cases, where a lookup and a resolve hit the same entry, expose any bypass or early write at once.

// File: rtl/btb_dir_pkg.sv
package btb_dir_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_MIN     = 2'b00;
    localparam ctr_t CTR_WEAK_NT = 2'b01;
    localparam ctr_t CTR_WEAK_T  = 2'b10;
    localparam ctr_t CTR_MAX     = 2'b11;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_ALLOC = 2'd1,
        RS_TRAIN = 2'd2
    } rs_kind_e;

    function automatic ctr_t ctr_step(ctr_t c, logic taken);
        ctr_t r;
        r = c;
        if (taken && c != CTR_MAX) r = c + 2'd1;
        else if (!taken && c != CTR_MIN) r = c - 2'd1;
        return r;
    endfunction

    function automatic logic ctr_dir(ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/btb_entry_table.sv
module btb_entry_table
    import btb_dir_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 512,
    parameter int HIST_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [PC_W-1:0]   lk_target,
    output logic [HIST_W-1:0] lk_hist,
    input  logic [IDX_W-1:0]  rs_idx,
    input  logic [TAG_W-1:0]  rs_tag,
    output logic              rs_hit,
    output logic [HIST_W-1:0] rs_hist,
    input  rs_kind_e          wr_kind,
    input  logic              wr_taken,
    input  logic [PC_W-1:0]   wr_target
);

    logic              valid_q [ENTRIES];
    logic [TAG_W-1:0]  tag_q   [ENTRIES];
    logic [PC_W-1:0]   tgt_q   [ENTRIES];
    logic [HIST_W-1:0] hist_q  [ENTRIES];

    // Lookup read port
    always_comb begin
        lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_target = tgt_q[lk_idx];
        lk_hist   = hist_q[lk_idx];
    end

    // Resolve read port (old contents, before this edge's write)
    always_comb begin
        rs_hit  = valid_q[rs_idx] && (tag_q[rs_idx] == rs_tag);
        rs_hist = hist_q[rs_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
        end else if (wr_kind == RS_ALLOC) begin
            valid_q[rs_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) begin
            case (wr_kind)
                RS_ALLOC: begin
                    tag_q[rs_idx]  <= rs_tag;
                    tgt_q[rs_idx]  <= wr_target;
                    hist_q[rs_idx] <= '0;
                end
                RS_TRAIN: begin
                    hist_q[rs_idx] <= {rs_hist[HIST_W-2:0], wr_taken};
                    if (wr_taken) tgt_q[rs_idx] <= wr_target;
                end
                default: ;
            endcase
        end
    end

    // R7: an allocated entry is valid on the following cycle
    p_alloc_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == RS_ALLOC) |=> valid_q[$past(rs_idx)]);

    // R11: nothing hits in the cycle after a reset cycle
    p_reset_empty_r11: assert property (@(posedge clk)
        $past(rst) |-> !lk_hit);

    // R8: training only ever follows a real tag match
    p_train_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_kind == RS_TRAIN) |-> rs_hit);

endmodule

// File: rtl/btb_counter_table.sv
module btb_counter_table
    import btb_dir_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_dir,
    input  rs_kind_e         upd_kind,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    ctr_t ctr_q [ENTRIES];
    ctr_t old_ctr;
    ctr_t nxt_ctr;

    assign rd_dir  = ctr_dir(ctr_q[rd_idx]);
    assign old_ctr = ctr_q[upd_idx];

    always_comb begin
        nxt_ctr = old_ctr;
        if (upd_kind == RS_TRAIN)      nxt_ctr = ctr_step(old_ctr, upd_taken);
        else if (upd_kind == RS_ALLOC) nxt_ctr = CTR_WEAK_T;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_WEAK_NT;
        end else if (upd_kind != RS_IDLE) begin
            ctr_q[upd_idx] <= nxt_ctr;
        end
    end

    // R6: a trained counter holds only at the saturating end of its move
    p_ctr_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_kind == RS_TRAIN) |->
            ((nxt_ctr == old_ctr) == (upd_taken ? (old_ctr == CTR_MAX) : (old_ctr == CTR_MIN))));

    // R6: the written value is what the counter holds one cycle later
    p_ctr_persist_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_kind == RS_TRAIN) |=> (ctr_q[$past(upd_idx)] == $past(nxt_ctr)));

    // R7: allocation leaves a weakly-taken counter
    p_alloc_weak_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_kind == RS_ALLOC) |=> (ctr_q[$past(upd_idx)] == CTR_WEAK_T));

endmodule

// File: rtl/btb_next_sel.sv
module btb_next_sel #(
    parameter int PC_W = 32
) (
    input  logic            hit,
    input  logic            dyn_dir,
    input  logic            back,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    output logic            taken,
    output logic [PC_W-1:0] next_pc
);

    logic [PC_W-1:0] seq_pc;

    assign seq_pc = pc + PC_W'(4);

    always_comb begin
        if (hit) begin
            taken   = dyn_dir;
            next_pc = dyn_dir ? target : seq_pc;
        end else begin
            taken   = back;
            next_pc = seq_pc;
        end
    end

endmodule

// File: rtl/btb_dir_pred.sv
module btb_dir_pred
    import btb_dir_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 512,
    parameter int HIST_W  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_back,
    output logic            lk_hit,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            rs_valid,
    input  logic [PC_W-1:2] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0]  lk_idx, rs_idx;
    logic [TAG_W-1:0]  lk_tag, rs_tag;
    logic [PC_W-1:0]   lk_target;
    logic [HIST_W-1:0] lk_hist, rs_hist;
    logic              rs_hit;
    logic              lk_dir;
    logic [IDX_W-1:0]  lk_pht_idx, rs_pht_idx;
    rs_kind_e          rs_kind;

    assign lk_idx = lk_pc[IDX_W+1:2];
    assign lk_tag = lk_pc[PC_W-1:IDX_W+2];
    assign rs_idx = rs_pc[IDX_W+1:2];
    assign rs_tag = rs_pc[PC_W-1:IDX_W+2];

    always_comb begin
        if (!rs_valid)    rs_kind = RS_IDLE;
        else if (rs_hit)  rs_kind = RS_TRAIN;
        else if (rs_taken) rs_kind = RS_ALLOC;
        else              rs_kind = RS_IDLE;
    end

    assign lk_pht_idx = lk_idx ^ IDX_W'(lk_hist);
    assign rs_pht_idx = (rs_kind == RS_ALLOC) ? rs_idx : (rs_idx ^ IDX_W'(rs_hist));

    btb_entry_table #(
        .PC_W    (PC_W),
        .ENTRIES (ENTRIES),
        .HIST_W  (HIST_W)
    ) u_entries (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .lk_hit    (lk_hit),
        .lk_target (lk_target),
        .lk_hist   (lk_hist),
        .rs_idx    (rs_idx),
        .rs_tag    (rs_tag),
        .rs_hit    (rs_hit),
        .rs_hist   (rs_hist),
        .wr_kind   (rs_kind),
        .wr_taken  (rs_taken),
        .wr_target (rs_target)
    );

    btb_counter_table #(
        .ENTRIES (ENTRIES)
    ) u_counters (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (lk_pht_idx),
        .rd_dir    (lk_dir),
        .upd_kind  (rs_kind),
        .upd_idx   (rs_pht_idx),
        .upd_taken (rs_taken)
    );

    btb_next_sel #(
        .PC_W (PC_W)
    ) u_sel (
        .hit     (lk_hit),
        .dyn_dir (lk_dir),
        .back    (lk_back),
        .pc      (lk_pc),
        .target  (lk_target),
        .taken   (lk_taken),
        .next_pc (lk_next_pc)
    );

    // R4: a miss always falls through to the sequential address
    p_miss_seq_r4: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_next_pc == lk_pc + PC_W'(4)));

    // R5: a miss follows the displacement sign
    p_miss_static_r5: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_taken == lk_back));

    // R3: a redirect away from the sequential path happens only on a taken hit
    p_redirect_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_next_pc != lk_pc + PC_W'(4)) |-> (lk_hit && lk_taken));

endmodule

// File: tb/btb_dir_pred_tb_top.sv
module btb_dir_pred_tb_top;

    localparam int PC_W    = 32;
    localparam int ENTRIES = 512;
    localparam int HIST_W  = 4;
    localparam int MAX_CYC = 100000;

    logic            clk = 1'b0;
    logic            rst;
    logic [PC_W-1:0] lk_pc;
    logic            lk_back;
    logic            lk_hit;
    logic            lk_taken;
    logic [PC_W-1:0] lk_next_pc;
    logic            rs_valid;
    logic [PC_W-1:2] rs_pc;
    logic            rs_taken;
    logic [PC_W-1:0] rs_target;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    btb_dir_pred #(
        .PC_W    (PC_W),
        .ENTRIES (ENTRIES),
        .HIST_W  (HIST_W)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .lk_pc      (lk_pc),
        .lk_back    (lk_back),
        .lk_hit     (lk_hit),
        .lk_taken   (lk_taken),
        .lk_next_pc (lk_next_pc),
        .rs_valid   (rs_valid),
        .rs_pc      (rs_pc),
        .rs_taken   (rs_taken),
        .rs_target  (rs_target)
    );

    // Reference model built from the requirements
    logic            m_valid [ENTRIES];
    logic [20:0]     m_tag   [ENTRIES];
    logic [31:0]     m_tgt   [ENTRIES];
    logic [3:0]      m_hist  [ENTRIES];
    logic [1:0]      m_ctr   [ENTRIES];

    typedef struct {
        logic        hit;
        logic        taken;
        logic [31:0] nxt;
        string       req;
    } exp_t;

    exp_t exp_q [$];

    function automatic void m_reset();
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 1'b0;
            m_tag[i]   = '0;
            m_tgt[i]   = '0;
            m_hist[i]  = '0;
            m_ctr[i]   = 2'd1;
        end
    endfunction

    function automatic exp_t m_look(logic [31:0] pc, logic back, string req);
        exp_t e;
        int   ix;
        ix = int'(pc[10:2]);
        e.req = req;
        e.hit = m_valid[ix] && (m_tag[ix] == pc[31:11]);
        if (e.hit) begin
            e.taken = m_ctr[ix ^ int'(m_hist[ix])][1];
            e.nxt   = e.taken ? m_tgt[ix] : pc + 32'd4;
        end else begin
            e.taken = back;
            e.nxt   = pc + 32'd4;
        end
        return e;
    endfunction

    function automatic void m_resolve(logic [31:0] pc, logic tk, logic [31:0] tgt);
        int ix, cx;
        ix = int'(pc[10:2]);
        if (m_valid[ix] && (m_tag[ix] == pc[31:11])) begin
            cx = ix ^ int'(m_hist[ix]);
            if (tk && m_ctr[cx] != 2'd3) m_ctr[cx] = m_ctr[cx] + 2'd1;
            else if (!tk && m_ctr[cx] != 2'd0) m_ctr[cx] = m_ctr[cx] - 2'd1;
            m_hist[ix] = {m_hist[ix][2:0], tk};
            if (tk) m_tgt[ix] = tgt;
        end else if (tk) begin
            m_valid[ix] = 1'b1;
            m_tag[ix]   = pc[31:11];
            m_tgt[ix]   = tgt;
            m_hist[ix]  = '0;
            m_ctr[ix]   = 2'd2;
        end
    endfunction

    // Driver: one cycle with a lookup and an optional resolve
    task automatic step(input logic [31:0] lpc, input logic back,
                        input logic rv, input logic [31:0] rpc, input logic rt,
                        input logic [31:0] rtg, input string req);
        @(posedge clk);
        #1;
        lk_pc     = lpc;
        lk_back   = back;
        rs_valid  = rv;
        rs_pc     = rpc[31:2];
        rs_taken  = rt;
        rs_target = rtg;
        exp_q.push_back(m_look(lpc, back, req));
        if (rv) m_resolve(rpc, rt, rtg);
    endtask

    task automatic look(input logic [31:0] lpc, input logic back, input string req);
        step(lpc, back, 1'b0, 32'h0, 1'b0, 32'h0, req);
    endtask

    task automatic res(input logic [31:0] rpc, input logic rt, input logic [31:0] rtg, input string req);
        step(32'h0000_0F00, 1'b0, 1'b1, rpc, rt, rtg, req);
    endtask

    // Monitor: compare every pending lookup mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (lk_hit !== e.hit || lk_taken !== e.taken || lk_next_pc !== e.nxt) begin
                errors++;
                $display("FAIL %s: got hit=%0b taken=%0b next=%h, expected hit=%0b taken=%0b next=%h",
                         e.req, lk_hit, lk_taken, lk_next_pc, e.hit, e.taken, e.nxt);
            end
        end
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lk_pc = '0; lk_back = 0; rs_valid = 0; rs_pc = '0; rs_taken = 0; rs_target = '0;
        rst = 1'b1;
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 R4 R5: empty table after reset
        look(32'h0000_1000, 1'b1, "R11 R5 backward miss");
        look(32'h0000_1000, 1'b0, "R11 R5 forward miss");
        look(32'hFFFF_FFFC, 1'b0, "R4 wrap sequential");

        // R8: not-taken miss allocates nothing
        res(32'h0000_2000, 1'b0, 32'h0000_2800, "R8 resolve");
        look(32'h0000_2000, 1'b0, "R8 no allocation");

        // R10 R7: same-cycle lookup sees old state, next cycle sees entry
        step(32'h0000_3000, 1'b0, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_2F00, "R10 same-cycle alloc");
        look(32'h0000_3000, 1'b0, "R7 allocated weakly taken");

        // R11 R3: history 1 selects an untouched weakly-not-taken counter
        res(32'h0000_3000, 1'b1, 32'h0000_2F00, "R6 train");
        look(32'h0000_3000, 1'b1, "R11 R3 untouched counter");

        // R2: same index, different tag
        look(32'h0000_3800, 1'b1, "R2 tag mismatch");
        look(32'h0001_3000, 1'b0, "R2 tag mismatch high");

        // R9: new target replaces old one after further taken outcomes
        for (int i = 0; i < 8; i++) begin
            res(32'h0000_3000, 1'b1, 32'h0000_4400, "R9 retarget");
            look(32'h0000_3000, 1'b0, "R9 target and history");
        end

        // R6: loop pattern T T T N, lookup before each resolve
        step(32'h0000_5000, 1'b0, 1'b1, 32'h0000_5000, 1'b1, 32'h0000_4000, "R7 loop alloc");
        for (int it = 0; it < 20; it++) begin
            for (int k = 0; k < 4; k++) begin
                look(32'h0000_5000, 1'b1, "R6 R3 loop pattern");
                res(32'h0000_5000, (k != 3), 32'h0000_4000, "R6 loop resolve");
            end
        end

        // R6: hysteresis, steady taken then two not-taken
        step(32'h0000_6000, 1'b0, 1'b1, 32'h0000_6000, 1'b1, 32'h0000_6100, "R7 alloc");
        for (int i = 0; i < 10; i++) res(32'h0000_6000, 1'b1, 32'h0000_6100, "R6 saturate");
        look(32'h0000_6000, 1'b0, "R6 saturated taken");
        res(32'h0000_6000, 1'b0, 32'h0, "R6 first miss");
        look(32'h0000_6000, 1'b0, "R6 after one wrong");
        res(32'h0000_6000, 1'b0, 32'h0, "R6 second miss");
        look(32'h0000_6000, 1'b0, "R6 after two wrong");

        // R1 R10: mixed traffic, lookup and resolve every cycle
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] lp, rp;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            lp = {19'h0, lfsr[1:0], 5'h0, lfsr[4:2], 2'b00} + 32'h0000_7000;
            rp = {19'h0, lfsr[6:5], 5'h0, lfsr[9:7], 2'b00} + 32'h0000_7000;
            step(lp, lfsr[11], lfsr[12] | lfsr[13], rp, lfsr[14] | lfsr[3],
                 {16'h0, lfsr} & 32'hFFFF_FFFC, "R1 R10 mixed");
        end

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule